// File: doc/BRIEF.md
# Two-Tone Test Signal Synthesizer

This block generates a digital test tone for one converter channel by adding two sinusoids, each programmed on its own. Every tone keeps a phase accumulator that advances by a programmable step on each sample strobe, looks its sine value up in a folded quarter-wave table, and multiplies that value by a signed amplitude factor. The two scaled tones are added together and clamped to the signed 16-bit range. The result leaves the block as one sample with a valid flag.

A single-cycle synchronisation pulse reloads both accumulators with their programmed start phases. Several channels pulsed together therefore restart in a known phase relationship. The step value is read on every strobe, so a new frequency applies from the next sample. A new start phase does nothing until the next synchronisation pulse.

Top module: `tone_pair_synth`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `sample_out` is 0 and `sample_valid` is 0. Both accumulators reset to 0.
- R2: On a clock edge with `step_en` high and `sync_req` low, each accumulator becomes (accumulator + step) modulo 2^16, using the step present at that edge.
- R3: On a clock edge with both `step_en` and `sync_req` low, neither accumulator changes.
- R4: On a clock edge with `sync_req` high, each accumulator loads its start phase, whether or not `step_en` is high. A change to a start phase without a synchronisation pulse has no effect on the output.
- R5: The sine of phase p is computed from i = p[15:6]. The quadrant is q = i[9:8] and the offset is a = i[7:0]. The table entry is T[k] = round(32767·sin(π/2·(k+0.5)/256)). The sine is T[a] for q=0, T[255−a] for q=1, −T[a] for q=2 and −T[255−a] for q=3. The sine is taken from the accumulator value held before the strobing edge.
- R6: Each tone's contribution is bits [29:14] of the 32-bit signed product of its sine and its scale, read as signed 16-bit. The scale is in 1.1.14 format, so 0x4000 is unity. The scale is read one cycle after the strobe.
- R7: The sum of the two contributions saturates to the range [−32768, 32767].
- R8: `sample_valid` is high exactly three clock edges after an edge that had `step_en` high. While `sample_valid` is low, `sample_out` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Sample strobe: take one sample and advance the accumulators |
| sync_req | input | 1 | Reload both accumulators with their start phases |
| tone_a_incr | input | 16 | Phase step of tone A |
| tone_a_init | input | 16 | Start phase of tone A |
| tone_a_scale | input | 16 | Signed 1.1.14 amplitude of tone A |
| tone_b_incr | input | 16 | Phase step of tone B |
| tone_b_init | input | 16 | Start phase of tone B |
| tone_b_scale | input | 16 | Signed 1.1.14 amplitude of tone B |
| sample_out | output | 16 | Saturated signed sum of both tones |
| sample_valid | output | 1 | Qualifies `sample_out` |

## Verification
A wrong accumulator value shows up at `sample_out` three edges after the strobe that reads it. From then on every following sample differs, because the phase error persists. A missed reload on synchronisation appears in the first sample that follows the pulse. A fault in table folding or product slicing corrupts only the samples in the affected quadrant or amplitude range. For this reason the tones sweep every table entry and use extreme scale values. A bench model that advances in step with the design compares the output on every clock, so each of these faults is caught within a few cycles of the stimulus that exposes it.

// File: rtl/tone_gen_pkg.sv
`timescale 1ns/1ps
package tone_gen_pkg;
    localparam int SMP_W   = 16;
    localparam int FRAC_W  = 14;
    localparam int PROD_W  = 2 * SMP_W;

    typedef logic signed [SMP_W-1:0] smp_t;

    function automatic smp_t clamp_sum(input logic signed [SMP_W:0] s);
        logic signed [SMP_W:0] hi;
        logic signed [SMP_W:0] lo;
        hi = (SMP_W+1)'((1 <<< (SMP_W-1)) - 1);
        lo = -(SMP_W+1)'(1 <<< (SMP_W-1));
        if (s > hi)      return hi[SMP_W-1:0];
        else if (s < lo) return lo[SMP_W-1:0];
        else             return s[SMP_W-1:0];
    endfunction
endpackage

// File: rtl/tone_phase_acc.sv
`timescale 1ns/1ps
module tone_phase_acc #(
    parameter int PHASE_DW = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_en,
    input  logic                reload,
    input  logic [15:0]         init_val,
    input  logic [15:0]         incr_val,
    output logic [PHASE_DW-1:0] phase
);
    localparam int PAD_W = PHASE_DW - 16;

    typedef struct packed {
        logic [PHASE_DW-1:0] acc;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic [PHASE_DW-1:0] init_ext, incr_ext;

    generate
        if (PAD_W > 0) begin : g_wide
            assign init_ext = {init_val, {PAD_W{1'b0}}};
            assign incr_ext = {incr_val, {PAD_W{1'b0}}};
        end else begin : g_exact
            assign init_ext = init_val;
            assign incr_ext = incr_val;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (reload)       st_d.acc = init_ext;
        else if (step_en) st_d.acc = st_q.acc + incr_ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign phase = st_q.acc;
endmodule

// File: rtl/quarter_sine_rom.sv
`timescale 1ns/1ps
module quarter_sine_rom #(
    parameter int PHASE_DW = 16,
    parameter int LUT_AW   = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cap_en,
    input  logic [PHASE_DW-1:0]     phase,
    output tone_gen_pkg::smp_t      sine
);
    import tone_gen_pkg::*;

    localparam int QAW    = LUT_AW - 2;
    localparam int QDEPTH = 1 << QAW;
    localparam int LO_W   = PHASE_DW - LUT_AW;

    typedef struct packed {
        smp_t sine;
    } rom_st_t;

    rom_st_t st_d, st_q;
    smp_t    qtab [QDEPTH];

    generate
        for (genvar k = 0; k < QDEPTH; k++) begin : g_tab
            localparam real ARG = 1.5707963267948966 * (real'(k) + 0.5) / real'(QDEPTH);
            localparam int  VAL = $rtoi(32767.0 * $sin(ARG) + 0.5);
            assign qtab[k] = SMP_W'(VAL);
        end
    endgenerate

    logic [LUT_AW-1:0] idx;
    logic [1:0]        quad;
    logic [QAW-1:0]    offs;
    logic [QAW-1:0]    addr;
    smp_t              mag;
    logic              unused_phase_lo;

    assign idx  = phase[PHASE_DW-1 -: LUT_AW];
    assign quad = idx[LUT_AW-1 -: 2];
    assign offs = idx[QAW-1:0];
    assign unused_phase_lo = ^phase[LO_W-1:0];

    always_comb begin
        st_d = st_q;
        addr = quad[0] ? ~offs : offs;
        mag  = qtab[addr];
        if (cap_en) st_d.sine = quad[1] ? -mag : mag;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sine = st_q.sine;
endmodule

// File: rtl/tone_scaler.sv
`timescale 1ns/1ps
module tone_scaler (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_en,
    input  tone_gen_pkg::smp_t sine,
    input  logic [15:0]        scale,
    output tone_gen_pkg::smp_t scaled
);
    import tone_gen_pkg::*;

    typedef struct packed {
        smp_t val;
    } scl_st_t;

    scl_st_t st_d, st_q;
    logic signed [PROD_W-1:0] prod;
    logic unused_prod_bits;

    assign prod = sine * $signed(scale);
    assign unused_prod_bits = ^{prod[PROD_W-1:FRAC_W+SMP_W], prod[FRAC_W-1:0]};

    always_comb begin
        st_d = st_q;
        if (cap_en) st_d.val = prod[FRAC_W+SMP_W-1:FRAC_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign scaled = st_q.val;
endmodule

// File: rtl/tone_pair_synth.sv
`timescale 1ns/1ps
module tone_pair_synth #(
    parameter int PHASE_DW = 16,
    parameter int LUT_AW   = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step_en,
    input  logic        sync_req,
    input  logic [15:0] tone_a_incr,
    input  logic [15:0] tone_a_init,
    input  logic [15:0] tone_a_scale,
    input  logic [15:0] tone_b_incr,
    input  logic [15:0] tone_b_init,
    input  logic [15:0] tone_b_scale,
    output logic [15:0] sample_out,
    output logic        sample_valid
);
    import tone_gen_pkg::*;

    localparam int NUM_TONES = 2;

    typedef struct packed {
        logic v_sine;
        logic v_scl;
        logic v_out;
        smp_t out;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [15:0]         incr_arr  [NUM_TONES];
    logic [15:0]         init_arr  [NUM_TONES];
    logic [15:0]         scale_arr [NUM_TONES];
    logic [PHASE_DW-1:0] acc_w     [NUM_TONES];
    smp_t                sine_w    [NUM_TONES];
    smp_t                scl_w     [NUM_TONES];
    logic [PHASE_DW-1:0] phase_a_mon;

    assign incr_arr[0]  = tone_a_incr;
    assign incr_arr[1]  = tone_b_incr;
    assign init_arr[0]  = tone_a_init;
    assign init_arr[1]  = tone_b_init;
    assign scale_arr[0] = tone_a_scale;
    assign scale_arr[1] = tone_b_scale;
    assign phase_a_mon  = acc_w[0];

    generate
        for (genvar t = 0; t < NUM_TONES; t++) begin : g_tone
            tone_phase_acc #(.PHASE_DW(PHASE_DW)) u_acc (
                .clk      (clk),
                .rst_n    (rst_n),
                .step_en  (step_en),
                .reload   (sync_req),
                .init_val (init_arr[t]),
                .incr_val (incr_arr[t]),
                .phase    (acc_w[t])
            );
            quarter_sine_rom #(.PHASE_DW(PHASE_DW), .LUT_AW(LUT_AW)) u_rom (
                .clk    (clk),
                .rst_n  (rst_n),
                .cap_en (step_en),
                .phase  (acc_w[t]),
                .sine   (sine_w[t])
            );
            tone_scaler u_scl (
                .clk    (clk),
                .rst_n  (rst_n),
                .cap_en (st_q.v_sine),
                .sine   (sine_w[t]),
                .scale  (scale_arr[t]),
                .scaled (scl_w[t])
            );
        end
    endgenerate

    always_comb begin
        logic signed [SMP_W:0] sum;
        st_d = st_q;
        sum  = '0;
        for (int t = 0; t < NUM_TONES; t++) sum = sum + (SMP_W+1)'(scl_w[t]);
        st_d.v_sine = step_en;
        st_d.v_scl  = st_q.v_sine;
        st_d.v_out  = st_q.v_scl;
        if (st_q.v_scl) st_d.out = clamp_sum(sum);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sample_out   = st_q.out;
    assign sample_valid = st_q.v_out;
endmodule

// File: rtl/tone_pair_synth_chk.sv
`timescale 1ns/1ps
module tone_pair_synth_chk #(
    parameter int PHASE_DW = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                step_en,
    input logic                sync_req,
    input logic [15:0]         tone_a_incr,
    input logic [15:0]         tone_a_init,
    input logic [PHASE_DW-1:0] phase_a,
    input logic [15:0]         sample_out,
    input logic                sample_valid
);
    logic [1:0] age_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           age_q <= '0;
        else if (age_q != 2'd3) age_q <= age_q + 2'd1;
    end

    assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req |=> phase_a[PHASE_DW-1 -: 16] == $past(tone_a_init));

    assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !sync_req) |=>
            phase_a[PHASE_DW-1 -: 16] == 16'($past(phase_a[PHASE_DW-1 -: 16]) + $past(tone_a_incr)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !sync_req) |=> $stable(phase_a));

    assert_valid_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (sample_valid == $past(step_en, 3)));

    assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid |-> $stable(sample_out));
endmodule

bind tone_pair_synth tone_pair_synth_chk #(.PHASE_DW(PHASE_DW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .step_en      (step_en),
    .sync_req     (sync_req),
    .tone_a_incr  (tone_a_incr),
    .tone_a_init  (tone_a_init),
    .phase_a      (phase_a_mon),
    .sample_out   (sample_out),
    .sample_valid (sample_valid)
);

// File: tb/test_tone_pair_synth.sv
`timescale 1ns/1ps
module test_tone_pair_synth;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic        sync_req = 1'b0;
    logic [15:0] tone_a_incr = '0, tone_a_init = '0, tone_a_scale = '0;
    logic [15:0] tone_b_incr = '0, tone_b_init = '0, tone_b_scale = '0;
    logic [15:0] sample_out;
    logic        sample_valid;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    live = 1'b0;
    int    qtab [256];

    int m_acc [2];
    int m_sin [2];
    int m_prd [2];
    int m_out;
    bit m_v1, m_v2, m_v3;
    int max_seen;

    always #2.5 clk = ~clk;

    tone_pair_synth i_tone_pair_synth (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .sync_req(sync_req),
        .tone_a_incr(tone_a_incr), .tone_a_init(tone_a_init), .tone_a_scale(tone_a_scale),
        .tone_b_incr(tone_b_incr), .tone_b_init(tone_b_init), .tone_b_scale(tone_b_scale),
        .sample_out(sample_out), .sample_valid(sample_valid)
    );

    initial begin
        for (int k = 0; k < 256; k++)
            qtab[k] = $rtoi(32767.0 * $sin(1.5707963267948966 * (real'(k) + 0.5) / 256.0) + 0.5);
    end

    function automatic int sine_of(input int ph);
        int i, q, a, m;
        i = (ph >> 6) & 1023;
        q = i >> 8;
        a = i & 255;
        m = (q & 1) ? qtab[255 - a] : qtab[a];
        return (q & 2) ? -m : m;
    endfunction

    function automatic int mulq(input int s, input logic [15:0] c);
        int p, r;
        p = s * int'($signed(c));
        r = (p >>> 14) & 32'hFFFF;
        if (r >= 32768) r -= 65536;
        return r;
    endfunction

    function automatic int sat16(input int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // Behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc = '{0, 0}; m_sin = '{0, 0}; m_prd = '{0, 0};
            m_out = 0; m_v1 = 0; m_v2 = 0; m_v3 = 0;
        end else begin
            if (m_v2) m_out = sat16(m_prd[0] + m_prd[1]);
            if (m_v1) begin
                m_prd[0] = mulq(m_sin[0], tone_a_scale);
                m_prd[1] = mulq(m_sin[1], tone_b_scale);
            end
            if (step_en) begin
                m_sin[0] = sine_of(m_acc[0]);
                m_sin[1] = sine_of(m_acc[1]);
            end
            if (sync_req) begin
                m_acc[0] = int'(tone_a_init);
                m_acc[1] = int'(tone_b_init);
            end else if (step_en) begin
                m_acc[0] = (m_acc[0] + int'(tone_a_incr)) & 32'hFFFF;
                m_acc[1] = (m_acc[1] + int'(tone_b_incr)) & 32'hFFFF;
            end
            m_v3 = m_v2; m_v2 = m_v1; m_v1 = step_en;
        end
    end

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (live) begin
            chk(int'($signed(sample_out)), m_out, cur_req);
            chk(int'(sample_valid), int'(m_v3), {cur_req, "/R8 valid"});
            if (int'($signed(sample_out)) > max_seen) max_seen = int'($signed(sample_out));
        end
    end

    task automatic run(input int n, input int en_mode);
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            case (en_mode)
                0: step_en = 1'b1;
                1: step_en = (c % 3) != 0;
                default: step_en = (c % 7) == 0;
            endcase
        end
    endtask

    task automatic pulse_sync();
        @(negedge clk); sync_req = 1'b1;
        @(negedge clk); sync_req = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: state during and just after reset
        chk(int'(sample_out), 0, "R1 reset out");
        chk(int'(sample_valid), 0, "R1 reset valid");
        rst_n = 1'b1;
        @(negedge clk);
        chk(int'(sample_out), 0, "R1 post-reset out");
        chk(int'(sample_valid), 0, "R1 post-reset valid");
        live = 1'b1;

        // R5: sweep every table entry, unity scale on tone A
        cur_req = "R5";
        tone_a_incr = 16'h0040; tone_a_scale = 16'h4000;
        run(1030, 0);

        // R3: gapped strobes with a second tone
        cur_req = "R3";
        tone_b_incr = 16'h0333; tone_b_scale = 16'h2000;
        run(300, 1);

        // R4: start phases take effect only on sync
        cur_req = "R4";
        tone_a_init = 16'h4000; tone_b_init = 16'h1000;
        run(20, 0);
        pulse_sync();
        run(60, 0);
        tone_a_init = 16'hA000;
        run(60, 0);
        @(negedge clk); step_en = 1'b0; sync_req = 1'b1;
        @(negedge clk); sync_req = 1'b0;
        run(40, 2);

        // R7: two unity tones in phase overflow and clamp
        cur_req = "R7";
        tone_a_incr = 16'h0100; tone_b_incr = 16'h0100;
        tone_a_init = 16'h0000; tone_b_init = 16'h0000;
        tone_a_scale = 16'h4000; tone_b_scale = 16'h4000;
        max_seen = -70000;
        pulse_sync();
        run(300, 0);
        chk(max_seen, 32767, "R7 positive clamp reached");

        // R6: extreme negative scale wraps inside the kept product bits
        cur_req = "R6";
        tone_a_scale = 16'h8000; tone_b_scale = 16'h0000;
        run(300, 0);
        tone_a_scale = 16'hC123; tone_b_scale = 16'h5FFF;
        run(300, 0);

        // R2: large steps wrap the accumulator; step change applies at once
        cur_req = "R2";
        tone_a_scale = 16'h4000; tone_b_scale = 16'h1800;
        tone_a_incr = 16'hF123; tone_b_incr = 16'h7777;
        run(150, 0);
        tone_a_incr = 16'h0011;
        run(150, 1);

        // R8: isolated strobes and idle gaps
        cur_req = "R8";
        run(200, 2);
        @(negedge clk); step_en = 1'b0;
        run(10, 2);

        live = 1'b0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired, actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule